// File: doc/BRIEF.md
# Coherence History Compatibility Matcher

This block decides whether the state history that a local cache recorded for one line fits the history that the shared cache recorded for the same line. Only the sequence of coherence states is used. Each entry is a 2-bit state: Modified, Exclusive, Shared or Invalid. Software or a loader writes both histories into the block's two internal stores while it is idle. It then pulses `start` and gives the number of valid entries in each store.

The check runs in three steps. First, each history is compressed: a run in which Modified (or Exclusive) alternates with Invalid collapses to one Modified (or Exclusive) entry. Next, the compressed local history is cut into partitions at every Invalid entry, and those Invalid entries are discarded. Finally, each partition is searched for, in order, as a contiguous run of the compressed shared history. Each partition is placed at its earliest position that starts after the end of the previous match.

The verdict is one of three values. A pass means every partition was found. A fail means no ordered placement exists. A skip means the search ran out of its cycle budget, so the line is left unchecked. The verdict stays on the outputs until the next accepted start.

Top module: `coh_hist_matcher`

## Requirements
- R1: After reset, `busy`, `valid` and `verdict` are all 0.
- R2: A run of M,I,M,I,...,M collapses to a single M in both histories before matching, and likewise for E. State encoding: I=2'b00, S=2'b01, E=2'b10, M=2'b11.
- R3: The local history is split at every I entry. The I entries are never matched against the shared history.
- R4: The partitions must be found in the same order as they occur in the local history. Otherwise the verdict is fail.
- R5: Each partition must occur as a contiguous run of the shared history. A partial match retries from the next shared position. If no placement exists, the verdict is fail.
- R6: A local history I,M,I,M,I,M,I,S,M,I checked against a shared history I,M,I,S,M,I,M gives pass.
- R7: A local history that is empty or contains only I gives pass, whatever the shared history holds.
- R8: If no decision is reached within BUDGET busy cycles (default 10000), the verdict is skip. In that case `valid` rises exactly BUDGET clock edges after the edge that accepted `start`. A decided check finishes in fewer edges.
- R9: A `start` that arrives while `busy` is high is ignored. A verdict stays stable, with `valid` high, until the next accepted start.
- R10: Verdict codes are pass=2'b01, fail=2'b10, skip=2'b11. `valid` is never high together with `busy`. `valid` rises on the same edge on which `busy` falls.
- R11: Writes to the history stores while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one history entry (taken only when idle) |
| wr_shared | input | 1 | 0 selects the local store, 1 selects the shared store |
| wr_addr | input | AW | Entry index to write |
| wr_state | input | 2 | State to write (I=00, S=01, E=10, M=11) |
| start | input | 1 | Begin a check (taken only when idle) |
| loc_len | input | LW | Number of local entries, clamped to DEPTH |
| shr_len | input | LW | Number of shared entries, clamped to DEPTH |
| busy | output | 1 | Check in progress |
| valid | output | 1 | Verdict available |
| verdict | output | 2 | 01 pass, 10 fail, 11 skip, 00 none |

## Verification
The check's duration depends on the data. The only latency that is fixed exactly is the budget case: `valid` rises exactly BUDGET edges after the edge that accepted `start`. Every decided case must finish in fewer edges than that.

The bench drives `start` for one edge and then counts edges, sampling at each falling edge, until `valid` is seen. It checks the verdict and the edge count at that sample, and it also checks that `busy` is already low. It samples again a few cycles later to confirm the verdict is unchanged.

// File: rtl/coh_hist_matcher.sv
module coh_hist_matcher #(
  parameter int DEPTH  = 256,
  parameter int BUDGET = 10000,
  parameter int AW     = $clog2(DEPTH),
  parameter int LW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_shared,
  input  logic [AW-1:0] wr_addr,
  input  logic [1:0]    wr_state,
  input  logic          start,
  input  logic [LW-1:0] loc_len,
  input  logic [LW-1:0] shr_len,
  output logic          busy,
  output logic          valid,
  output logic [1:0]    verdict
);
  localparam int CW = $clog2(BUDGET + 1);
  localparam logic [1:0] ST_I = 2'b00;
  localparam logic [1:0] V_PASS = 2'b01, V_FAIL = 2'b10, V_SKIP = 2'b11;
  localparam logic [LW-1:0] DMAX = LW'(DEPTH);

  typedef enum logic [1:0] {PH_IDLE, PH_CMP, PH_MATCH} ph_t;
  ph_t phase;

  logic [1:0]    mem [2][DEPTH];
  logic [LW-1:0] len [2];
  logic [LW-1:0] wp  [2];
  logic [1:0]    t0  [2];
  logic [1:0]    t1  [2];
  logic [1:0]    cur [2];
  logic          act [2];
  logic          pop [2];
  logic [LW-1:0] idx, li, si, lp, sa;
  logic          inpart;
  logic [CW-1:0] cnt;
  logic          dec;
  logic [1:0]    dv;

  assign busy = (phase != PH_IDLE);

  wire [LW-1:0] loc_len_c = (loc_len > DMAX) ? DMAX : loc_len;
  wire [LW-1:0] shr_len_c = (shr_len > DMAX) ? DMAX : shr_len;

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      cur[s] = mem[s][idx[AW-1:0]];
      act[s] = (phase == PH_CMP) && (idx < len[s]);
      pop[s] = act[s] && cur[s][1] && (t1[s] == ST_I) && (t0[s] == cur[s]) && (wp[s] >= LW'(2));
    end
  end

  wire [1:0] lcur   = mem[0][li[AW-1:0]];
  wire [1:0] scur   = mem[1][si[AW-1:0]];
  wire       l_end  = (li == len[0]);
  wire       p_end  = l_end || (lcur == ST_I);
  wire       s_end  = (si == len[1]);
  wire       budget_hit = (cnt == CW'(BUDGET - 1));

  always_comb begin
    dec = 1'b0;
    dv  = V_PASS;
    if (phase == PH_MATCH) begin
      if (!inpart && l_end) begin
        dec = 1'b1;
        dv  = V_PASS;
      end else if (inpart && !p_end && s_end) begin
        dec = 1'b1;
        dv  = V_FAIL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (phase == PH_IDLE && wr_en)
      mem[wr_shared][wr_addr] <= wr_state;
    for (int s = 0; s < 2; s++)
      if (act[s] && !pop[s])
        mem[s][wp[s][AW-1:0]] <= cur[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      valid   <= 1'b0;
      verdict <= 2'b00;
      idx     <= '0;
      li      <= '0;
      si      <= '0;
      lp      <= '0;
      sa      <= '0;
      inpart  <= 1'b0;
      cnt     <= '0;
      for (int s = 0; s < 2; s++) begin
        len[s] <= '0;
        wp[s]  <= '0;
        t0[s]  <= ST_I;
        t1[s]  <= ST_I;
      end
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase   <= PH_CMP;
          valid   <= 1'b0;
          verdict <= 2'b00;
          len[0]  <= loc_len_c;
          len[1]  <= shr_len_c;
          idx     <= '0;
          cnt     <= '0;
          li      <= '0;
          si      <= '0;
          lp      <= '0;
          sa      <= '0;
          inpart  <= 1'b0;
          for (int s = 0; s < 2; s++) begin
            wp[s] <= '0;
            t0[s] <= ST_I;
            t1[s] <= ST_I;
          end
        end
        PH_CMP: begin
          cnt <= cnt + 1'b1;
          for (int s = 0; s < 2; s++) begin
            if (act[s]) begin
              if (pop[s]) begin
                wp[s] <= wp[s] - 1'b1;
                t1[s] <= cur[s];
                t0[s] <= ST_I;
              end else begin
                wp[s] <= wp[s] + 1'b1;
                t0[s] <= t1[s];
                t1[s] <= cur[s];
              end
            end
          end
          if (idx >= len[0] && idx >= len[1]) begin
            phase  <= PH_MATCH;
            len[0] <= wp[0];
            len[1] <= wp[1];
          end else begin
            idx <= idx + 1'b1;
          end
          if (budget_hit) begin
            phase   <= PH_IDLE;
            valid   <= 1'b1;
            verdict <= V_SKIP;
          end
        end
        PH_MATCH: begin
          cnt <= cnt + 1'b1;
          if (!inpart) begin
            if (!l_end) begin
              if (lcur == ST_I) li <= li + 1'b1;
              else begin
                inpart <= 1'b1;
                lp     <= li;
                sa     <= si;
              end
            end
          end else if (p_end) begin
            inpart <= 1'b0;
          end else if (!s_end) begin
            if (lcur == scur) begin
              li <= li + 1'b1;
              si <= si + 1'b1;
            end else begin
              sa <= sa + 1'b1;
              si <= sa + 1'b1;
              li <= lp;
            end
          end
          if (dec) begin
            phase   <= PH_IDLE;
            valid   <= 1'b1;
            verdict <= dv;
          end else if (budget_hit) begin
            phase   <= PH_IDLE;
            valid   <= 1'b1;
            verdict <= V_SKIP;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coh_hist_matcher_chk.sv
module coh_hist_matcher_chk #(
  parameter int BUDGET = 10000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       valid,
  input logic [1:0] verdict
);
  int unsigned run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else run_cnt <= 0;
  end

  p_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (verdict != 2'b00));

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && busy));

  p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !start) |=> (valid && $stable(verdict)));

  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && run_cnt > 0) |=> (busy || valid));

  p_budget_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < BUDGET));

  p_skip_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(valid) && verdict == 2'b11) |-> ($past(run_cnt) == BUDGET - 1));
endmodule

bind coh_hist_matcher coh_hist_matcher_chk #(.BUDGET(BUDGET)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .valid(valid), .verdict(verdict)
);

// File: tb/coh_hist_matcher_bench.sv
module coh_hist_matcher_bench;
  localparam int DEPTH = 256;
  localparam int BUDGET = 10000;
  localparam int AW = 8;
  localparam int LW = 9;
  localparam logic [1:0] PASS = 2'b01, FAIL_V = 2'b10, SKIP = 2'b11;
  localparam int NV = 16;

  localparam string VL [NV] = '{"M", "MIMIM", "EIEIE", "MIM", "MS", "ISI", "SIM", "MIS",
                                "SM", "IMIMIMISMI", "", "IIII", "S", "ES", "SSE", "EIM"};
  localparam string VS [NV] = '{"MIMIM", "M", "SE", "SMS", "MIMS", "MSE", "MS", "MS",
                                "SEM", "IMISMIM", "EM", "", "", "SES", "SSSE", "ME"};
  localparam logic [1:0] VX [NV] = '{PASS, PASS, PASS, PASS, PASS, PASS, FAIL_V, PASS,
                                     FAIL_V, PASS, PASS, PASS, FAIL_V, PASS, PASS, FAIL_V};
  localparam string VT [NV] = '{"R2", "R2", "R2", "R2", "R2", "R3", "R4", "R4",
                                "R5", "R6", "R7", "R7", "R5", "R5", "R5", "R4"};

  logic clk = 0, rst_n = 0, wr_en = 0, wr_shared = 0, start = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [1:0] wr_state = '0;
  logic [LW-1:0] loc_len = '0, shr_len = '0;
  logic busy, valid;
  logic [1:0] verdict;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  coh_hist_matcher u_coh_hist_matcher (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_shared(wr_shared),
    .wr_addr(wr_addr), .wr_state(wr_state), .start(start),
    .loc_len(loc_len), .shr_len(shr_len), .busy(busy),
    .valid(valid), .verdict(verdict)
  );

  function automatic logic [1:0] enc(byte c);
    case (c)
      "M": return 2'b11;
      "E": return 2'b10;
      "S": return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(bit side, int a, logic [1:0] st);
    @(negedge clk);
    wr_en = 1; wr_shared = side; wr_addr = AW'(a); wr_state = st;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic go(int ll, int sl, output int n);
    @(negedge clk);
    loc_len = LW'(ll); shr_len = LW'(sl); start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    n = 0;
    while (!valid && n < BUDGET + 10) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic [1:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(valid == 0, "R1 valid", valid, 0);
    check(verdict == 0, "R1 verdict", verdict, 0);
    rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < VL[v].len(); i++) put(0, i, enc(VL[v][i]));
      for (int i = 0; i < VS[v].len(); i++) put(1, i, enc(VS[v][i]));
      go(VL[v].len(), VS[v].len(), n);
      check(verdict == VX[v], VT[v], verdict, VX[v]);
      check(n < BUDGET, {VT[v], " latency"}, n, BUDGET - 1);
      check(busy == 0, "R10 busy low with valid", busy, 0);
      if (v == 0) begin
        held = verdict;
        repeat (5) @(negedge clk);
        check(valid && verdict == held, "R9 verdict held", verdict, held);
      end
    end

    // R8 budget exhausted: local S*127 E, shared S*256
    for (int i = 0; i < 128; i++) put(0, i, (i < 127) ? 2'b01 : 2'b10);
    for (int i = 0; i < 256; i++) put(1, i, 2'b01);
    go(128, 256, n);
    check(verdict == SKIP, "R8 skip verdict", verdict, SKIP);
    check(n == BUDGET, "R8 skip latency", n, BUDGET);

    // R9 start while busy ignored, R11 write while busy ignored
    @(negedge clk);
    loc_len = 9'd128; shr_len = 9'd256; start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    repeat (600) @(negedge clk);
    wr_en = 1; wr_shared = 0; wr_addr = 8'd127; wr_state = 2'b01;
    start = 1;
    loc_len = 9'd1;
    @(negedge clk);
    wr_en = 0; start = 0;
    n = 601;
    while (!valid && n < BUDGET + 10) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    check(n == BUDGET, "R9 start ignored while busy", n, BUDGET);
    check(verdict == SKIP, "R9 verdict after ignored start", verdict, SKIP);
    go(128, 256, n);
    check(verdict == SKIP, "R11 write while busy ignored", verdict, SKIP);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule